// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block lets a clocked system read and write an external 512K x 8 asynchronous static RAM. The user side offers a valid/ready request port with a write flag, a 19-bit address and 8-bit write data. Read results come back on a registered data bus with a one-cycle valid strobe. The memory side drives active-low chip select, output enable and write enable, a registered address bus, and a data bus split into output value, driver enable and input value. The tri-state pad sits outside the block.

Each access runs through separately counted phases: address setup, strobe, then either write recovery or bus release. The length of each phase comes from a table of nanosecond limits for the chosen speed grade (45, 55 or 70). Each limit is converted to whole clocks with ceil(t / CLK_PERIOD_NS), and any zero-nanosecond gap between two edges is rounded up to one cycle. Changing the clock period or the speed grade therefore needs no other edit.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is asserted and in the first idle cycle after it, chip select, output enable and write enable are high, the data drivers are off, req_ready is 1 and rsp_valid is 0.
- R2: A write drives chip select low for one setup cycle, then write enable low for max(ceil(35/T), ceil(25/T), ceil(45/T)-2) cycles, then one recovery cycle with write enable high and chip select still low. T is CLK_PERIOD_NS, and the figures are for the 45 grade. Write enable is never low while chip select is high.
- R3: A read drives chip select low for one setup cycle, then output enable low for max(ceil(25/T), ceil(45/T)-1) cycles. The bus is sampled on the last clock of that window. rsp_valid is high for exactly one cycle, carrying the stored byte.
- R4: Output enable stays high for the whole of a write, and write enable stays high for the whole of a read. The data drivers are never on while output enable is low.
- R5: The address stays constant while chip select is low. Write data stays constant while write enable is low.
- R6: After a read, chip select and output enable are high and the drivers are off for max(1, ceil(20/T)) cycles. The drivers are not turned on sooner than that after output enable rises.
- R7: req_ready is high only when the block is idle. It stays low from the cycle after acceptance until the access is complete. A write is busy for 2 + write strobe cycles, and a read for 1 + read strobe + release cycles.
- R8: A request held valid while the block is busy is accepted exactly once, when req_ready returns high.
- R9: With no request pending, chip select, output enable and write enable stay high and the drivers stay off.
- R10: Writes at the lowest (0) and highest (0x7FFFF) addresses, and repeated writes to one address, read back with the last value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Byte address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle |
| rsp_rdata | output | 8 | Registered read data |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_addr | output | 19 | Memory address bus |
| mem_dq_o | output | 8 | Value for the data pad drivers |
| mem_dq_oe | output | 1 | Data pad driver enable |
| mem_dq_i | input | 8 | Value seen on the data pads |

## Verification
The assertions assume that req_addr, req_write and req_wdata are stable while req_valid is high and req_ready is low. They also assume that mem_dq_i carries no meaning except in the final cycle of an output-enable window. The driver only changes the request fields on a falling clock edge after it has seen an acceptance. The memory model returns unknown values on the bus until 45 ns of stable address has passed, and it drops any write pulse shorter than 35 ns. A sequencer that shortens a phase therefore produces wrong data rather than silently passing.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_SETUP  = 3'd1,
    PH_STROBE = 3'd2,
    PH_RECOV  = 3'd3,
    PH_TURN   = 3'd4
  } phase_e;

  // nanosecond limits of one speed grade
  typedef struct packed {
    int unsigned t_cyc_rd;
    int unsigned t_acc_addr;
    int unsigned t_acc_oe;
    int unsigned t_release;
    int unsigned t_cyc_wr;
    int unsigned t_we_pulse;
    int unsigned t_data_setup;
    int unsigned t_addr_setup;
    int unsigned t_wr_recov;
  } grade_t;

  // clock counts of each phase
  typedef struct packed {
    int unsigned setup;
    int unsigned wr_strobe;
    int unsigned wr_recov;
    int unsigned rd_strobe;
    int unsigned rd_turn;
  } cycles_t;

  function automatic grade_t grade_limits(input int unsigned grade);
    grade_t g;
    case (grade)
      55: g = '{t_cyc_rd: 55, t_acc_addr: 55, t_acc_oe: 30, t_release: 20,
                t_cyc_wr: 55, t_we_pulse: 40, t_data_setup: 25,
                t_addr_setup: 0, t_wr_recov: 0};
      70: g = '{t_cyc_rd: 70, t_acc_addr: 70, t_acc_oe: 35, t_release: 25,
                t_cyc_wr: 70, t_we_pulse: 50, t_data_setup: 30,
                t_addr_setup: 0, t_wr_recov: 0};
      default: g = '{t_cyc_rd: 45, t_acc_addr: 45, t_acc_oe: 25, t_release: 20,
                     t_cyc_wr: 45, t_we_pulse: 35, t_data_setup: 25,
                     t_addr_setup: 0, t_wr_recov: 0};
    endcase
    return g;
  endfunction

  function automatic int unsigned ceil_cyc(input int unsigned ns, input int unsigned per);
    return (ns + per - 1) / per;
  endfunction

  function automatic int unsigned at_least_one(input int unsigned c);
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned sat_sub(input int unsigned a, input int unsigned b);
    return (a > b) ? a - b : 0;
  endfunction

  function automatic cycles_t derive_cycles(input int unsigned grade, input int unsigned per);
    grade_t  g;
    cycles_t c;
    g           = grade_limits(grade);
    c.setup     = at_least_one(ceil_cyc(g.t_addr_setup, per));
    c.wr_recov  = at_least_one(ceil_cyc(g.t_wr_recov, per));
    c.wr_strobe = at_least_one(max2(max2(ceil_cyc(g.t_we_pulse, per),
                                         ceil_cyc(g.t_data_setup, per)),
                                    sat_sub(ceil_cyc(g.t_cyc_wr, per),
                                            c.setup + c.wr_recov)));
    c.rd_strobe = at_least_one(max2(ceil_cyc(g.t_acc_oe, per),
                                    max2(sat_sub(ceil_cyc(g.t_acc_addr, per), c.setup),
                                         sat_sub(ceil_cyc(g.t_cyc_rd, per), c.setup))));
    c.rd_turn   = at_least_one(ceil_cyc(g.t_release, per));
    return c;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q;

  // a phase loaded with N lasts N clocks; done marks its last clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val - CNT_W'(1);
    else if (cnt_q != '0)    cnt_q <= cnt_q - CNT_W'(1);
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int               CNT_W     = 8,
  parameter logic [CNT_W-1:0] SETUP_N   = 1,
  parameter logic [CNT_W-1:0] WR_STRB_N = 10,
  parameter logic [CNT_W-1:0] WR_REC_N  = 1,
  parameter logic [CNT_W-1:0] RD_STRB_N = 11,
  parameter logic [CNT_W-1:0] RD_TURN_N = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic             req_write,
  input  logic             tmr_done,
  output phase_e           phase_q,
  output phase_e           phase_d,
  output logic             wr_d,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             capture
);
  logic wr_q;

  always_comb begin
    phase_d  = phase_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    capture  = 1'b0;
    wr_d     = wr_q;
    unique case (phase_q)
      PH_IDLE: if (fire) begin
        phase_d  = PH_SETUP;
        wr_d     = req_write;
        tmr_load = 1'b1;
        tmr_val  = SETUP_N;
      end
      PH_SETUP: if (tmr_done) begin
        phase_d  = PH_STROBE;
        tmr_load = 1'b1;
        tmr_val  = wr_q ? WR_STRB_N : RD_STRB_N;
      end
      PH_STROBE: if (tmr_done) begin
        phase_d  = wr_q ? PH_RECOV : PH_TURN;
        tmr_load = 1'b1;
        tmr_val  = wr_q ? WR_REC_N : RD_TURN_N;
        capture  = !wr_q;
      end
      PH_RECOV, PH_TURN: if (tmr_done) phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      wr_q    <= 1'b0;
    end else begin
      phase_q <= phase_d;
      wr_q    <= wr_d;
    end
  end
endmodule

// File: rtl/sram_pin_drive.sv
module sram_pin_drive
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  phase_e            phase_d,
  input  logic              wr_d,
  input  logic              capture,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic              mem_cs_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);
  logic selected_d;
  assign selected_d = (phase_d == PH_SETUP) || (phase_d == PH_STROBE) ||
                      (phase_d == PH_RECOV);

  // strobes are registered from the next phase so the pins never glitch
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_cs_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_dq_oe <= 1'b0;
    end else begin
      mem_cs_n  <= !selected_d;
      mem_we_n  <= !((phase_d == PH_STROBE) && wr_d);
      mem_oe_n  <= !((phase_d == PH_STROBE) && !wr_d);
      mem_dq_oe <= selected_d && wr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr <= '0;
      mem_dq_o <= '0;
    end else if (accept) begin
      mem_addr <= req_addr;
      mem_dq_o <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= capture;
      if (capture) rsp_rdata <= mem_dq_i;
    end
  end
endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 4,
  parameter int SPEED_GRADE   = 45,
  parameter int ADDR_W        = 19,
  parameter int DATA_W        = 8,
  parameter int CNT_W         = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mem_cs_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_i
);
  localparam cycles_t CYC = derive_cycles(SPEED_GRADE, CLK_PERIOD_NS);
  localparam logic [CNT_W-1:0] SETUP_N   = CNT_W'(CYC.setup);
  localparam logic [CNT_W-1:0] WR_STRB_N = CNT_W'(CYC.wr_strobe);
  localparam logic [CNT_W-1:0] WR_REC_N  = CNT_W'(CYC.wr_recov);
  localparam logic [CNT_W-1:0] RD_STRB_N = CNT_W'(CYC.rd_strobe);
  localparam logic [CNT_W-1:0] RD_TURN_N = CNT_W'(CYC.rd_turn);

  phase_e           phase_q, phase_d;
  logic             wr_d;
  logic             tmr_load, tmr_done;
  logic [CNT_W-1:0] tmr_val;

  // named events for the checker
  logic             accept;
  logic             capture;
  logic [CNT_W-1:0] turn_cycles;

  assign req_ready   = (phase_q == PH_IDLE);
  assign accept      = req_valid && req_ready;
  assign turn_cycles = RD_TURN_N;

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .done(tmr_done)
  );

  sram_seq_fsm #(
    .CNT_W(CNT_W), .SETUP_N(SETUP_N), .WR_STRB_N(WR_STRB_N), .WR_REC_N(WR_REC_N),
    .RD_STRB_N(RD_STRB_N), .RD_TURN_N(RD_TURN_N)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .fire(accept), .req_write(req_write),
    .tmr_done(tmr_done), .phase_q(phase_q), .phase_d(phase_d), .wr_d(wr_d),
    .tmr_load(tmr_load), .tmr_val(tmr_val), .capture(capture)
  );

  sram_pin_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .clk(clk), .rst_n(rst_n), .accept(accept), .req_addr(req_addr),
    .req_wdata(req_wdata), .phase_d(phase_d), .wr_d(wr_d), .capture(capture),
    .mem_dq_i(mem_dq_i), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_addr(mem_addr), .mem_dq_o(mem_dq_o),
    .mem_dq_oe(mem_dq_oe), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );
endmodule

// File: rtl/sram_async_ctrl_chk.sv
module sram_async_ctrl_chk #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              accept,
  input logic              rsp_valid,
  input logic              mem_cs_n,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_dq_o,
  input logic              mem_dq_oe,
  input logic [CNT_W-1:0]  turn_cycles
);
  logic [7:0] oe_high_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  oe_high_run <= 8'hFF;
    else if (!mem_oe_n)          oe_high_run <= 8'h00;
    else if (oe_high_run != 8'hFF) oe_high_run <= oe_high_run + 8'd1;
  end

  p_we_inside_cs_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> !mem_cs_n);

  p_recovery_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (!mem_cs_n && mem_dq_oe));

  p_rsp_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_strobes_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_oe_n);

  p_no_contention_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);

  p_addr_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));

  p_wdata_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && $past(!mem_we_n)) |-> $stable(mem_dq_o));

  p_release_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> (oe_high_run >= 8'(turn_cycles)));

  p_busy_after_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);

  p_busy_while_selected_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_cs_n |-> !req_ready);
endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .accept(accept),
  .rsp_valid(rsp_valid), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n),
  .mem_we_n(mem_we_n), .mem_addr(mem_addr), .mem_dq_o(mem_dq_o),
  .mem_dq_oe(mem_dq_oe), .turn_cycles(turn_cycles)
);

// File: tb/sram_async_ctrl_tb.sv
module sram_async_ctrl_tb;
  localparam int T = 4;

  function automatic int cdiv(input int ns);
    return (ns + T - 1) / T;
  endfunction
  function automatic int mx(input int a, input int b);
    return a > b ? a : b;
  endfunction

  localparam int WE_LOW  = mx(mx(cdiv(35), cdiv(25)), cdiv(45) - 2);
  localparam int OE_LOW  = mx(cdiv(25), cdiv(45) - 1);
  localparam int RELEASE = mx(1, cdiv(20));
  localparam int WR_BUSY = 2 + WE_LOW;
  localparam int RD_BUSY = 1 + OE_LOW + RELEASE;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [18:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic req_ready, rsp_valid, mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [7:0]  rsp_rdata, mem_dq_o;
  logic [7:0]  mem_dq_i = 8'hzz;
  logic [18:0] mem_addr;

  int n_checks = 0, n_fail = 0;
  logic [7:0] mdl [int unsigned];
  logic [7:0] shadow [int unsigned];
  logic [7:0] exp_q [$];
  bit last_kind_wr = 1'b0;

  always #(T/2) clk = ~clk;

  sram_async_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_cs_n(mem_cs_n),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_addr(mem_addr),
    .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  // memory model: data appears only after 45 ns of stable address, short pulses are lost
  int acc_run = 0, we_run = 0, last_we_run = 0;
  int unsigned wr_a;
  logic [7:0] wr_d;
  logic [18:0] prev_addr = '0;
  logic [7:0]  prev_dq = '0;
  bit prev_cs_low = 0, prev_we_low = 0, prev_oe_low = 0, prev_dq_oe = 0;
  int viol_addr = 0, viol_wdata = 0, viol_excl = 0, viol_wecs = 0, viol_gap = 0;
  int oe_gap = 255, gap_checks = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_cs_n || (prev_cs_low && mem_addr != prev_addr)) acc_run = 0;
      else if (!prev_cs_low) acc_run = 0;
      else acc_run++;
      if (!mem_cs_n && !mem_oe_n && (acc_run * 2 * T + T >= 90))
        mem_dq_i = mdl.exists(mem_addr) ? mdl[mem_addr] : 8'hxx;
      else if (!mem_cs_n && !mem_oe_n)
        mem_dq_i = 8'hxx;
      else
        mem_dq_i = 8'hzz;

      if (!mem_cs_n && !mem_we_n) begin
        we_run++;
        wr_a = mem_addr;
        wr_d = mem_dq_oe ? mem_dq_o : 8'hxx;
      end else if (we_run > 0) begin
        last_we_run = we_run;
        if (we_run * T >= 35) mdl[wr_a] = wr_d;
        we_run = 0;
      end

      // R4 R5 R2 pin rules observed at the ports
      if (!mem_cs_n && prev_cs_low && mem_addr != prev_addr) viol_addr++;
      if (!mem_we_n && prev_we_low && mem_dq_o != prev_dq) viol_wdata++;
      if ((mem_dq_oe && !mem_oe_n) || (!mem_we_n && !mem_oe_n)) viol_excl++;
      if (!mem_we_n && mem_cs_n) viol_wecs++;
      // R6 gap from output enable release to driver turn-on
      if (mem_dq_oe && !prev_dq_oe && oe_gap < 255) begin
        gap_checks++;
        if (oe_gap < RELEASE) viol_gap++;
        oe_gap = 255;
      end
      if (!mem_oe_n) oe_gap = 0;
      else if (prev_oe_low) oe_gap = 1;
      else if (oe_gap < 255) oe_gap++;

      prev_cs_low = !mem_cs_n;
      prev_we_low = !mem_we_n;
      prev_oe_low = !mem_oe_n;
      prev_dq_oe  = mem_dq_oe;
      prev_addr   = mem_addr;
      prev_dq     = mem_dq_o;
    end
  end

  // busy-length monitor (R7) and strobe width (R2)
  int busy = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (!req_ready) busy++;
      else if (busy > 0) begin
        if (last_kind_wr) begin
          check(busy == WR_BUSY, "R7 write busy", busy, WR_BUSY);
          check(last_we_run == WE_LOW, "R2 write strobe width", last_we_run, WE_LOW);
        end else
          check(busy == RD_BUSY, "R7 read busy", busy, RD_BUSY);
        busy = 0;
      end
    end
  end

  // scoreboard monitor (R3)
  bit prev_rsp = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (rsp_valid) begin
        if (exp_q.size() == 0)
          check(1'b0, "R3 unexpected response", rsp_rdata, 0);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          check(rsp_rdata === e, "R3 read data", rsp_rdata, e);
        end
      end
      if (rsp_valid && prev_rsp) check(1'b0, "R3 valid longer than one cycle", 2, 1);
      prev_rsp = rsp_valid;
    end
  end

  // R8: valid is raised at once and held until acceptance
  task automatic issue(input bit wr, input logic [18:0] a, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    last_kind_wr = wr;
    if (wr) shadow[a] = d;
    else exp_q.push_back(shadow[a]);
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!req_ready || exp_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(mem_cs_n && mem_oe_n && mem_we_n && !mem_dq_oe && req_ready && !rsp_valid,
          "R1 pins in reset", {mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe, req_ready, rsp_valid},
          6'b111010);
    rst_n = 1'b1;
    @(negedge clk);
    check(mem_cs_n && mem_oe_n && mem_we_n && !mem_dq_oe && req_ready,
          "R1 first idle cycle", {mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe, req_ready},
          5'b11101);

    // R10 extremes and a spread of patterns
    issue(1, 19'h00000, 8'hA5);
    issue(1, 19'h7FFFF, 8'h5A);
    issue(1, 19'h12345, 8'hFF);
    issue(1, 19'h00001, 8'h00);
    issue(0, 19'h00000, 8'h00);
    issue(0, 19'h7FFFF, 8'h00);
    issue(0, 19'h12345, 8'h00);
    issue(0, 19'h00001, 8'h00);
    // R10 overwrite of one address
    issue(1, 19'h2AAAA, 8'h11);
    issue(1, 19'h2AAAA, 8'h3C);
    issue(0, 19'h2AAAA, 8'h00);
    // R6 read followed at once by a write, then readback
    issue(0, 19'h12345, 8'h00);
    issue(1, 19'h55555, 8'hC3);
    issue(0, 19'h55555, 8'h00);
    issue(1, 19'h00002, 8'h81);
    wait_idle();

    // R9 idle with no request
    begin
      bit quiet = 1;
      repeat (8) begin
        @(negedge clk);
        if (!(mem_cs_n && mem_oe_n && mem_we_n && !mem_dq_oe)) quiet = 0;
      end
      check(quiet, "R9 idle pins", quiet, 1);
    end
    check(viol_addr == 0, "R5 address change under chip select", viol_addr, 0);
    check(viol_wdata == 0, "R5 write data change under write enable", viol_wdata, 0);
    check(viol_excl == 0, "R4 strobe or driver overlap", viol_excl, 0);
    check(viol_wecs == 0, "R2 write enable outside chip select", viol_wecs, 0);
    check(gap_checks > 0 && viol_gap == 0, "R6 release gap", viol_gap, 0);
    check(exp_q.size() == 0, "R3 responses outstanding", exp_q.size(), 0);
    finish_run();
  end
endmodule